// File: doc/BRIEF.md
# Three-Wire Serial Host Command Sequencer

This block is the host end of a three-wire serial port: a free-running-while-selected clock, an active-low select and one shared data line, split here into output, output-enable and input. A local client hands it one command at a time over a valid/ready interface. A command is either a register write (7-bit address plus 8-bit data) or a register read (7-bit address). The block serializes the command as a 16-bit frame and brackets it with the select line. For a read, it turns the data line around and collects the returned byte. It then reports completion with a one-cycle pulse, which carries the byte for reads.

The attached peripheral needs quiet time in several places. It needs a pause between the address half and the data half of a read. It also needs a minimum idle time between commands, and that minimum depends on whether the previous command was a write or a read and on which kind comes next. The sequencer holds its ready output low until the applicable gap has elapsed, so the client never has to count cycles. A command can be cut short with an abort strobe. The gap rules still apply after an aborted command, keyed on the type of that command.

Top module: `tws_host_seq`

## Requirements
- R1: Out of reset and whenever no command is in flight: `csn`=1, `sclk`=1, `sdio_oe`=0, `rsp_done`=0. `req_ready`=1 out of reset, since no gap is pending then.
- R2: A frame is 16 bits, shifted MSB first and sampled by the peripheral on rising `sclk`. Bit 15 is the direction: 1 for write, 0 for read. Bits 14..8 are the address, MSB first. Bits 7..0 are the data byte, which for a write is `req_wdata`, MSB first.
- R3: While `csn`=0 and `sdio_oe`=1, `sdio_o` does not change during a high phase of `sclk`. New bits appear together with a falling edge.
- R4: `sdio_oe`=1 for all 8 address-phase bits and for write data. `sdio_oe`=0 for the 8 data bits of a read.
- R5: Read data on `sdio_i` is captured at each of the 8 data-phase rising edges, MSB first. It is returned on `rsp_rdata` with a single-cycle `rsp_done` in the same cycle that `csn` rises. Completed writes also pulse `rsp_done`.
- R6: In a read, at least `A2D_GAP` system cycles separate the 8th rising edge of `sclk` from the 9th falling edge.
- R7: After a write, a following write's first falling `sclk` edge comes at least `GAP_WW` cycles after the previous frame's 16th rising edge.
- R8: After a write, a following read's first falling edge comes at least `GAP_WR` cycles after the previous 16th rising edge.
- R9: After a read, the next command's first falling edge comes at least `GAP_RR` cycles later for a read, or `GAP_RW` cycles later for a write, measured from the previous 16th rising edge.
- R10: `req_abort` while `csn`=0 raises `csn` and releases the line at the next edge, with no `rsp_done`. The next command still honours the R7–R9 gap for the aborted command's type, measured from the `csn` rise.
- R11: Every low phase of `sclk` lasts exactly `CLK_LO` cycles. The first falling edge comes exactly `CLK_HI` cycles after `csn` falls. Every high phase between bits lasts exactly `CLK_HI` cycles, except the address-to-data pause of a read.
- R12: `req_ready`=0 while `csn`=0. A request is taken on `req_valid && req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request present |
| req_ready | output | 1 | Sequencer idle and inter-command gap satisfied |
| req_write | input | 1 | 1 = write command, 0 = read command |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| req_abort | input | 1 | Cut the current frame short |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| sclk | output | 1 | Serial clock, idles high |
| csn | output | 1 | Active-low select |
| sdio_o | output | 1 | Data line value driven by the host |
| sdio_oe | output | 1 | Data line output enable |
| sdio_i | input | 1 | Data line value seen by the host |

## Verification
The assertions assume that the client holds `req_write`, `req_addr` and `req_wdata` steady from the time `req_valid` rises until acceptance. This matters because `req_ready` looks at `req_write` to pick the gap. They also assume that `req_abort` is a short strobe that falls inside a frame. The bench driver changes request fields only on the falling system clock edge and keeps them unchanged until it sees `req_ready`. It pulses `req_abort` for exactly one cycle after counting a chosen number of rising `sclk` edges. The modelled peripheral changes `sdio_i` only after a falling `sclk` edge in the data half of a read.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LO,
    ST_HI,
    ST_WAIT
  } tws_state_e;

  function automatic int unsigned tws_max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Minimum cycles from the reference event of the previous command
  // to the first falling clock of the next one.
  function automatic int unsigned tws_gap_need(logic prev_wr, logic next_wr,
                                               int unsigned ww, int unsigned wr,
                                               int unsigned rw, int unsigned rr);
    if (prev_wr) return next_wr ? ww : wr;
    return next_wr ? rw : rr;
  endfunction

endpackage

// File: rtl/tws_phase_cnt.sv
module tws_phase_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int unsigned TXW = 16,
  parameter int unsigned RXW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_val,
  input  logic           shift_tx,
  input  logic           shift_rx,
  input  logic           rx_bit,
  output logic           tx_bit,
  output logic [RXW-1:0] rx_byte
);
  logic [TXW-1:0] tx_q;
  logic [RXW-1:0] rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)          tx_q <= load_val;
      else if (shift_tx) tx_q <= {tx_q[TXW-2:0], 1'b0};
      if (shift_rx)      rx_q <= {rx_q[RXW-2:0], rx_bit};
    end
  end

  assign tx_bit  = tx_q[TXW-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/tws_gap_track.sv
module tws_gap_track
  import tws_pkg::*;
#(
  parameter int unsigned GAP_WW = 20,
  parameter int unsigned GAP_WR = 30,
  parameter int unsigned GAP_RW = 35,
  parameter int unsigned GAP_RR = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic mark_wr,
  input  logic next_wr,
  output logic gap_ok
);
  localparam int unsigned GMAX = tws_max2(tws_max2(GAP_WW, GAP_WR),
                                          tws_max2(GAP_RW, GAP_RR));
  localparam int unsigned GW   = $clog2(GMAX + 1);

  logic          have_prev_q;
  logic          prev_wr_q;
  logic [GW-1:0] since_q;
  logic [GW-1:0] need_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev_q <= 1'b0;
      prev_wr_q   <= 1'b0;
      since_q     <= '0;
    end else if (mark) begin
      have_prev_q <= 1'b1;
      prev_wr_q   <= mark_wr;
      since_q     <= '0;
    end else if (since_q != GW'(GMAX)) begin
      since_q     <= since_q + 1'b1;
    end
  end

  assign need_w = GW'(tws_gap_need(prev_wr_q, next_wr, GAP_WW, GAP_WR, GAP_RW, GAP_RR));
  assign gap_ok = !have_prev_q || (since_q >= need_w);
endmodule

// File: rtl/tws_host_seq.sv
module tws_host_seq
  import tws_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_LO  = 2,
  parameter int unsigned CLK_HI  = 3,
  parameter int unsigned A2D_GAP = 6,
  parameter int unsigned GAP_WW  = 20,
  parameter int unsigned GAP_WR  = 30,
  parameter int unsigned GAP_RW  = 35,
  parameter int unsigned GAP_RR  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_abort,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              sclk,
  output logic              csn,
  output logic              sdio_o,
  output logic              sdio_oe,
  input  logic              sdio_i
);
  localparam int unsigned HEAD_BITS  = ADDR_W + 1;
  localparam int unsigned FRAME_BITS = HEAD_BITS + DATA_W;
  localparam int unsigned BW         = $clog2(FRAME_BITS);
  localparam int unsigned PMAX       = tws_max2(tws_max2(CLK_LO, CLK_HI), A2D_GAP);
  localparam int unsigned PW         = $clog2(PMAX + 1);

  tws_state_e        state_q;
  logic [BW-1:0]     bitn_q;
  logic              is_wr_q, csn_q, sclk_q, oe_q, done_q;
  logic [DATA_W-1:0] rdata_q, rx_byte;
  logic              cnt_zero, cnt_load, gap_ok, tx_bit;
  logic [PW-1:0]     cnt_val;

  // Named internal events
  logic accept, abort_evt, lo_done, hi_done, last_bit, head_end;
  logic in_rd_data, last_rise, frame_end, shift_rx, shift_tx;

  assign req_ready  = (state_q == ST_IDLE) && gap_ok;
  assign accept     = req_valid && req_ready;
  assign abort_evt  = req_abort && (state_q != ST_IDLE);
  assign lo_done    = (state_q == ST_LO) && cnt_zero;
  assign hi_done    = (state_q == ST_HI) && cnt_zero;
  assign last_bit   = (bitn_q == BW'(FRAME_BITS - 1));
  assign head_end   = (bitn_q == BW'(HEAD_BITS - 1));
  assign in_rd_data = !is_wr_q && (bitn_q >= BW'(HEAD_BITS));
  assign last_rise  = lo_done && last_bit && !abort_evt;
  assign frame_end  = hi_done && last_bit && !abort_evt;
  assign shift_rx   = lo_done && in_rd_data && !abort_evt;
  assign shift_tx   = hi_done && !last_bit && !abort_evt;

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin cnt_load = 1'b1; cnt_val = PW'(CLK_HI - 1); end
      ST_LEAD: if (cnt_zero) begin cnt_load = 1'b1; cnt_val = PW'(CLK_LO - 1); end
      ST_LO:   if (cnt_zero) begin cnt_load = 1'b1; cnt_val = PW'(CLK_HI - 1); end
      ST_HI:   if (cnt_zero && !last_bit) begin
                 cnt_load = 1'b1;
                 cnt_val  = (head_end && !is_wr_q) ? PW'(A2D_GAP - 1) : PW'(CLK_LO - 1);
               end
      ST_WAIT: if (cnt_zero) begin cnt_load = 1'b1; cnt_val = PW'(CLK_LO - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bitn_q  <= '0;
      is_wr_q <= 1'b0;
      csn_q   <= 1'b1;
      sclk_q  <= 1'b1;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_evt) begin
        state_q <= ST_IDLE;
        csn_q   <= 1'b1;
        sclk_q  <= 1'b1;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (accept) begin
            state_q <= ST_LEAD;
            csn_q   <= 1'b0;
            oe_q    <= 1'b1;
            is_wr_q <= req_write;
            bitn_q  <= '0;
          end
          ST_LEAD: if (cnt_zero) begin state_q <= ST_LO; sclk_q <= 1'b0; end
          ST_LO:   if (cnt_zero) begin state_q <= ST_HI; sclk_q <= 1'b1; end
          ST_HI: if (cnt_zero) begin
            if (last_bit) begin
              state_q <= ST_IDLE;
              csn_q   <= 1'b1;
              oe_q    <= 1'b0;
              done_q  <= 1'b1;
              rdata_q <= rx_byte;
            end else begin
              bitn_q <= bitn_q + 1'b1;
              if (head_end && !is_wr_q) begin
                state_q <= ST_WAIT;
                oe_q    <= 1'b0;
              end else begin
                state_q <= ST_LO;
                sclk_q  <= 1'b0;
              end
            end
          end
          ST_WAIT: if (cnt_zero) begin state_q <= ST_LO; sclk_q <= 1'b0; end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  tws_phase_cnt #(.W(PW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  tws_shift #(.TXW(FRAME_BITS), .RXW(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_val({req_write, req_addr, req_wdata}),
    .shift_tx(shift_tx), .shift_rx(shift_rx), .rx_bit(sdio_i),
    .tx_bit(tx_bit), .rx_byte(rx_byte)
  );

  tws_gap_track #(.GAP_WW(GAP_WW), .GAP_WR(GAP_WR), .GAP_RW(GAP_RW), .GAP_RR(GAP_RR)) u_gap (
    .clk(clk), .rst_n(rst_n), .mark(last_rise || abort_evt), .mark_wr(is_wr_q),
    .next_wr(req_write), .gap_ok(gap_ok)
  );

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;
  assign sclk      = sclk_q;
  assign csn       = csn_q;
  assign sdio_o    = tx_bit;
  assign sdio_oe   = oe_q;
endmodule

// File: rtl/tws_host_seq_chk.sv
module tws_host_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic sclk,
  input logic sdio_o,
  input logic sdio_oe,
  input logic req_ready,
  input logic rsp_done
);
  a_r1_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> sclk);

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sdio_oe);

  a_r2_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !csn);

  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && $past(!csn) && sclk && $past(sclk) && sdio_oe && $past(sdio_oe))
      |-> $stable(sdio_o));

  a_r4_release_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdio_oe) && !csn) |-> sclk);

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r5_done_at_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(csn));

  a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !csn |-> !req_ready);
endmodule

bind tws_host_seq tws_host_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdio_o(sdio_o),
  .sdio_oe(sdio_oe), .req_ready(req_ready), .rsp_done(rsp_done)
);

// File: tb/tws_host_seq_bench.sv
module tws_host_seq_bench;
  localparam int CLK_LO = 2, CLK_HI = 3, A2D = 6;
  localparam int GWW = 20, GWR = 30, GRW = 35, GRR = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_abort = 1'b0, sdio_i = 1'b0;
  logic [6:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_done, sclk, csn, sdio_o, sdio_oe;
  logic [7:0] rsp_rdata;

  always #2 clk = ~clk;

  tws_host_seq #(.CLK_LO(CLK_LO), .CLK_HI(CLK_HI), .A2D_GAP(A2D),
                 .GAP_WW(GWW), .GAP_WR(GWR), .GAP_RW(GRW), .GAP_RR(GRR)) u_tws_host_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_abort(req_abort), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sclk(sclk), .csn(csn), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdio_i(sdio_i)
  );

  typedef struct { logic wr; logic [6:0] a; logic [7:0] d; logic ab; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0, stray_done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Peripheral answer for a read of address a
  function automatic logic [7:0] periph_byte(input logic [6:0] a);
    return 8'(({1'b0, a} * 8'd37) + 8'd11);
  endfunction

  function automatic int min_gap(input logic pw, input logic nw);
    case ({pw, nw})
      2'b11:   return GWW;
      2'b10:   return GWR;
      2'b01:   return GRW;
      default: return GRR;
    endcase
  endfunction

  function automatic string gap_tag(input logic pw, input logic nw);
    if (pw) return nw ? "R7 write->write gap" : "R8 write->read gap";
    return "R9 read->next gap";
  endfunction

  // ---------------- monitor / scoreboard ----------------
  int cyc = 0;
  logic p_sclk = 1'b1, p_csn = 1'b1, p_sdo = 1'b0, p_oe = 1'b0;
  int rises = 0, falls = 0, t_csn_fall = 0, t_rise = 0, t_fall = 0, a2d_seen = 0, first_gap = 0;
  logic [15:0] bits = '0;
  logic have_ref = 1'b0, ref_wr = 1'b0, f_have_prev = 1'b0, f_prev_wr = 1'b0;
  int t_ref = 0, f_tref = 0;
  logic shape_err, stab_err, oe_err, rdy_err;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (p_csn && !csn) begin
      rises = 0; falls = 0; bits = '0; t_csn_fall = cyc; a2d_seen = 0;
      shape_err = 0; stab_err = 0; oe_err = 0; rdy_err = 0;
      f_have_prev = have_ref; f_prev_wr = ref_wr; f_tref = t_ref;
    end
    if (!csn) begin
      if (req_ready) rdy_err = 1;
      if (sclk && p_sclk && sdio_oe && p_oe && (sdio_o !== p_sdo)) stab_err = 1;
      if (!p_sclk && sclk) begin
        rises++;
        bits[16 - rises] = p_sdo;
        if (cyc - t_fall != CLK_LO) shape_err = 1;
        if (p_oe !== ((rises <= 8) || bits[15])) oe_err = 1;
        if (rises == 16) begin t_ref = cyc; ref_wr = bits[15]; have_ref = 1; end
        t_rise = cyc;
      end
      if (p_sclk && !sclk) begin
        falls++;
        if (falls == 1) begin
          if (cyc - t_csn_fall != CLK_HI) shape_err = 1;
          first_gap = cyc - f_tref;
        end else if (falls == 9 && !bits[15]) begin
          a2d_seen = cyc - t_rise;
        end else if (cyc - t_rise != CLK_HI) shape_err = 1;
        if (falls >= 9 && !bits[15]) sdio_i = periph_byte(bits[14:8])[7 - (falls - 9)];
        t_fall = cyc;
      end
    end
    if (!p_csn && csn) begin
      exp_t e;
      if (exp_q.size() == 0) check(0, "R2 unexpected frame", 1, 0);
      else begin
        e = exp_q.pop_front();
        if (e.ab) begin
          check(rises < 16 && !rsp_done, "R10 aborted frame ends without done", rises, 0);
          t_ref = cyc; ref_wr = e.wr; have_ref = 1;
        end else begin
          check(rises == 16, "R2 frame length", rises, 16);
          if (e.wr) check(bits == {1'b1, e.a, e.d}, "R2 write frame bits", bits, {1'b1, e.a, e.d});
          else      check(bits[15:8] == {1'b0, e.a}, "R2 read header bits", bits[15:8], {1'b0, e.a});
          check(rsp_done === 1'b1, "R5 done with deselect", rsp_done, 1);
          if (!e.wr) begin
            check(rsp_rdata == periph_byte(e.a), "R5 read data", rsp_rdata, periph_byte(e.a));
            check(a2d_seen >= A2D, "R6 address-to-data pause", a2d_seen, A2D);
          end
        end
        check(!shape_err, "R11 clock phase lengths", shape_err, 0);
        check(!stab_err, "R3 data stable while clock high", stab_err, 0);
        check(!oe_err, "R4 output enable per phase", oe_err, 0);
        check(!rdy_err, "R12 ready low while selected", rdy_err, 0);
        if (f_have_prev)
          check(first_gap >= min_gap(f_prev_wr, e.wr), gap_tag(f_prev_wr, e.wr),
                first_gap, min_gap(f_prev_wr, e.wr));
      end
    end else if (rsp_done) stray_done++;
    p_sclk = sclk; p_csn = csn; p_sdo = sdio_o; p_oe = sdio_oe;
  end

  // ---------------- driver ----------------
  task automatic send(input logic wr, input logic [6:0] a, input logic [7:0] d, input logic ab);
    exp_t e;
    e.wr = wr; e.a = a; e.d = d; e.ab = ab;
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_abort(input logic wr, input logic [6:0] a, input logic [7:0] d, input int n);
    send(wr, a, d, 1'b1);
    repeat (n) @(posedge sclk);
    @(negedge clk);
    req_abort = 1'b1;
    @(negedge clk);
    req_abort = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", exp_q.size());
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(csn && sclk && !sdio_oe && !rsp_done, "R1 reset state lines",
          {csn, sclk, sdio_oe, rsp_done}, 4'b1100);
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);

    send(1'b1, 7'h15, 8'hA6, 1'b0);
    send(1'b1, 7'h7F, 8'h00, 1'b0);   // R7
    send(1'b0, 7'h21, 8'h00, 1'b0);   // R8
    send(1'b0, 7'h00, 8'h00, 1'b0);   // R9 read->read
    send(1'b1, 7'h40, 8'hFF, 1'b0);   // R9 read->write
    send(1'b0, 7'h5A, 8'h00, 1'b0);
    send_abort(1'b1, 7'h0C, 8'h3C, 5);  // R10 abort inside address
    send(1'b0, 7'h33, 8'h00, 1'b0);
    send_abort(1'b0, 7'h6E, 8'h00, 11); // R10 abort inside read data
    send(1'b1, 7'h01, 8'h5C, 1'b0);
    send(1'b1, 7'h2B, 8'h81, 1'b0);

    repeat (200) @(negedge clk);
    check(exp_q.size() == 0, "R2 all frames seen", exp_q.size(), 0);
    check(stray_done == 0, "R5 no done outside frame end", stray_done, 0);
    check(csn && sclk && !sdio_oe, "R1 idle lines after traffic", {csn, sclk, sdio_oe}, 3'b110);
    finish_run();
  end
endmodule